// File: doc/BRIEF.md
# Classifier-Gated Binary CAM

This block is a binary content-addressable memory. Its entries are grouped into sub-blocks of equal size, and each sub-block can be enabled for comparison on its own. A small trained classifier sits in front of the array. For each search it predicts which sub-blocks could hold the tag, and only those sub-blocks run an exact full-width comparison. The other sub-blocks stay idle.

The classifier keeps a few low bits of the tag, which form the reduced tag. It cuts these bits into equal subtags. Each subtag picks one row of its own bit-matrix of connections, and each column of a matrix belongs to one entry. A write stores the tag at an entry address and, in the same cycle, sets that entry's column bit in the selected row of every matrix. Nothing else is cleared, so adding an entry never disturbs the training of the other entries.

A search ANDs the selected rows across the matrices to get candidate entries. It then ORs the candidates of each sub-block to form that sub-block's enable. False candidates are removed by the exact compare, so a stored tag is never missed. The result appears one cycle after the request.

Top module: `cgcam`

## Requirements
- R1: While reset is held, and in the first cycle after it, `rslt_vld`, `rslt_hit`, `rslt_addr` and `rslt_nen` are all 0. Reset clears every entry and every classifier connection, so a search made after reset misses and reports 0 enabled sub-blocks.
- R2: A write stores `wr_tag` at `wr_addr`. A later search for that exact tag reports `rslt_hit`=1 and `rslt_addr`=that address.
- R3: `rslt_vld` is 1 in exactly the cycle after each cycle in which `srch_en` is 1, and is 0 otherwise.
- R4: A search for a tag held by no valid entry gives `rslt_hit`=0 and `rslt_addr`=0.
- R5: When several valid entries hold the searched tag, `rslt_addr` is the lowest of their addresses.
- R6: The reduced tag is tag bits [RED_W-1:0]. Subtag k is bits [k*SUB_W +: SUB_W] of the reduced tag and selects row k of its matrix. Entry e is a candidate when, for every k, some write to e since reset had subtag k equal to the searched subtag k. Sub-block g holds entries g*GRP to g*GRP+GRP-1. `rslt_nen` is the number of sub-blocks that hold at least one candidate.
- R7: A candidate whose full stored tag differs from the searched tag is never reported. A tag that shares its reduced bits with stored entries, but whose full value is held by none of them, misses while `rslt_nen` is nonzero.
- R8: Rewriting an address with a new tag replaces its stored tag. The old tag no longer hits at that address, the new tag does, and the old connections stay set.
- R9: A search in the same cycle as a write sees the contents as they were before that write.
- R10: In a cycle after one without a search, `rslt_hit`, `rslt_addr` and `rslt_nen` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Store the tag and train the classifier |
| wr_addr | input | AW | Entry address for the write |
| wr_tag | input | TAG_W | Tag to store |
| srch_en | input | 1 | Search request |
| srch_tag | input | TAG_W | Tag to look up |
| rslt_vld | output | 1 | Result strobe, one cycle after the request |
| rslt_hit | output | 1 | A valid entry holds the searched tag |
| rslt_addr | output | AW | Lowest matching address, 0 on a miss |
| rslt_nen | output | CW | Number of sub-blocks enabled for the search |

## Verification
A write and a search can land in the same cycle, and these two functions contend for the same storage. The bench provokes this by driving a new tag on the write port and the same tag on the search port in one cycle, to an address below every other entry. The result of that search must miss, and its enable count must come from the classifier state before the write. A search repeated in the next cycle must hit at the newly written address. Overwrites and cross-trained entries also set up classifier false positives, and the exact compare must filter these out.

// File: rtl/cgcam_pkg.sv
// cgcam_pkg: default sizes and shared types for the classifier-gated CAM.
// Assumes: users derive every other width from these defaults.
package cgcam_pkg;
    localparam int DEF_ENTRIES = 16;
    localparam int DEF_TAG_W   = 16;
    localparam int DEF_RED_W   = 8;
    localparam int DEF_SUB_W   = 4;
    localparam int DEF_GRP     = 4;

    // Operation kind used by stimulus tables.
    typedef enum logic {
        OP_WRITE  = 1'b0,
        OP_SEARCH = 1'b1
    } cgcam_op_e;
endpackage

// File: rtl/cgcam_conn_mem.sv
// cgcam_conn_mem: one cluster's connection matrix, ROWS x COLS bits held in flops.
// A write sets one bit; bits are never cleared except by reset.
// Assumes: the read row is combinational, so a same-cycle write is not seen.
module cgcam_conn_mem #(
    parameter int ROWS = 16,
    parameter int COLS = 16,
    localparam int RW  = $clog2(ROWS),
    localparam int CLW = $clog2(COLS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [RW-1:0]   wr_row,
    input  logic [CLW-1:0]  wr_col,
    input  logic [RW-1:0]   rd_row,
    output logic [COLS-1:0] rd_bits
);
    logic [COLS-1:0] mem [ROWS];

    // Clear on reset; otherwise set the addressed connection bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < ROWS; r++) mem[r] <= '0;
        end else if (wr_en) begin
            mem[wr_row][wr_col] <= 1'b1;
        end
    end

    // Present the row selected by the search subtag.
    always_comb rd_bits = mem[rd_row];
endmodule

// File: rtl/cgcam_classifier.sv
// cgcam_classifier: turns the reduced tag into per-sub-block compare enables.
// There is one connection matrix per cluster. The candidates are the AND across
// clusters, and each enable is the OR over a group of GRP entries.
// Assumes: RED_W is a multiple of SUB_W and ENTRIES is a multiple of GRP.
module cgcam_classifier #(
    parameter int ENTRIES = 16,
    parameter int RED_W   = 8,
    parameter int SUB_W   = 4,
    parameter int GRP     = 4,
    localparam int CLUST  = RED_W / SUB_W,
    localparam int ROWS   = 1 << SUB_W,
    localparam int NGRP   = ENTRIES / GRP,
    localparam int AW     = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [RED_W-1:0] wr_red,
    input  logic [RED_W-1:0] srch_red,
    output logic [NGRP-1:0]  grp_en
);
    logic [ENTRIES-1:0] rows_rd [CLUST];
    logic [ENTRIES-1:0] cand;

    for (genvar k = 0; k < CLUST; k++) begin : g_clust
        cgcam_conn_mem #(.ROWS(ROWS), .COLS(ENTRIES)) u_mem (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_en),
            .wr_row  (wr_red[k*SUB_W +: SUB_W]),
            .wr_col  (wr_addr),
            .rd_row  (srch_red[k*SUB_W +: SUB_W]),
            .rd_bits (rows_rd[k])
        );
    end

    // An entry is a candidate only if every cluster row points at it.
    always_comb begin
        cand = '1;
        for (int k = 0; k < CLUST; k++) cand &= rows_rd[k];
    end

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        // A sub-block is enabled if it holds any candidate.
        assign grp_en[g] = |cand[g*GRP +: GRP];
    end
endmodule

// File: rtl/cgcam_array.sv
// cgcam_array: tag storage with a valid bit per entry and gated exact compare.
// Only entries in enabled sub-blocks compare; the lowest matching index wins.
// Assumes: a write lands at the clock edge, so a same-cycle search sees old data.
module cgcam_array #(
    parameter int ENTRIES = 16,
    parameter int TAG_W   = 16,
    parameter int GRP     = 4,
    localparam int NGRP   = ENTRIES / GRP,
    localparam int AW     = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [TAG_W-1:0] srch_tag,
    input  logic [NGRP-1:0]  grp_en,
    output logic             hit,
    output logic [AW-1:0]    hit_addr
);
    logic [TAG_W-1:0]   tags [ENTRIES];
    logic [ENTRIES-1:0] valid;
    logic [ENTRIES-1:0] match;

    // Store the tag and mark the entry valid; reset invalidates all entries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= '0;
            for (int e = 0; e < ENTRIES; e++) tags[e] <= '0;
        end else if (wr_en) begin
            valid[wr_addr] <= 1'b1;
            tags[wr_addr]  <= wr_tag;
        end
    end

    for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
        // Compare only inside an enabled sub-block.
        assign match[e] = grp_en[e / GRP] && valid[e] && (tags[e] == srch_tag);
    end

    // Lowest-index priority encoder over the match vector.
    always_comb begin
        hit      = 1'b0;
        hit_addr = '0;
        for (int e = ENTRIES - 1; e >= 0; e--) begin
            if (match[e]) begin
                hit      = 1'b1;
                hit_addr = AW'(e);
            end
        end
    end
endmodule

// File: rtl/cgcam.sv
// cgcam: top of the classifier-gated binary CAM. The classifier gates the array,
// and the result is registered one cycle after the search request.
// Assumes: ENTRIES is a power of two, RED_W <= TAG_W, and sizes divide evenly.
module cgcam #(
    parameter int ENTRIES = cgcam_pkg::DEF_ENTRIES,
    parameter int TAG_W   = cgcam_pkg::DEF_TAG_W,
    parameter int RED_W   = cgcam_pkg::DEF_RED_W,
    parameter int SUB_W   = cgcam_pkg::DEF_SUB_W,
    parameter int GRP     = cgcam_pkg::DEF_GRP,
    localparam int NGRP   = ENTRIES / GRP,
    localparam int AW     = $clog2(ENTRIES),
    localparam int CW     = $clog2(NGRP + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic             srch_en,
    input  logic [TAG_W-1:0] srch_tag,
    output logic             rslt_vld,
    output logic             rslt_hit,
    output logic [AW-1:0]    rslt_addr,
    output logic [CW-1:0]    rslt_nen
);
    logic [NGRP-1:0] grp_en;
    logic            arr_hit;
    logic [AW-1:0]   arr_addr;
    logic [CW-1:0]   en_cnt;

    cgcam_classifier #(
        .ENTRIES (ENTRIES), .RED_W (RED_W), .SUB_W (SUB_W), .GRP (GRP)
    ) u_cls (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_red   (wr_tag[RED_W-1:0]),
        .srch_red (srch_tag[RED_W-1:0]),
        .grp_en   (grp_en)
    );

    cgcam_array #(
        .ENTRIES (ENTRIES), .TAG_W (TAG_W), .GRP (GRP)
    ) u_arr (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_tag   (wr_tag),
        .srch_tag (srch_tag),
        .grp_en   (grp_en),
        .hit      (arr_hit),
        .hit_addr (arr_addr)
    );

    // Count the sub-blocks the classifier enabled.
    always_comb begin
        en_cnt = '0;
        for (int g = 0; g < NGRP; g++) en_cnt = en_cnt + CW'(grp_en[g]);
    end

    // Register the result and its strobe; hold the fields between searches.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rslt_vld  <= 1'b0;
            rslt_hit  <= 1'b0;
            rslt_addr <= '0;
            rslt_nen  <= '0;
        end else begin
            rslt_vld <= srch_en;
            if (srch_en) begin
                rslt_hit  <= arr_hit;
                rslt_addr <= arr_addr;
                rslt_nen  <= en_cnt;
            end
        end
    end
endmodule

// File: rtl/cgcam_checker.sv
// cgcam_checker: temporal properties on the CAM result port, bound to cgcam.
module cgcam_checker #(
    parameter int AW = 4,
    parameter int CW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          srch_en,
    input logic          rslt_vld,
    input logic          rslt_hit,
    input logic [AW-1:0] rslt_addr,
    input logic [CW-1:0] rslt_nen
);
    // Reset drives the result port to zero.
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (!rslt_vld && !rslt_hit && rslt_addr == '0 && rslt_nen == '0));

    // The strobe follows the request by exactly one cycle.
    assert_strobe_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
        srch_en |=> rslt_vld);
    assert_no_spurious_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !srch_en |=> !rslt_vld);

    // A miss reports address zero.
    assert_miss_addr_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rslt_vld && !rslt_hit) |-> rslt_addr == '0);

    // A hit can only come from an enabled sub-block.
    assert_hit_needs_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rslt_hit |-> rslt_nen != '0);

    // Fields hold when there was no search.
    assert_hold_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !srch_en) |=> ($stable(rslt_hit) && $stable(rslt_addr) && $stable(rslt_nen)));
endmodule

bind cgcam cgcam_checker #(.AW(AW), .CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .srch_en   (srch_en),
    .rslt_vld  (rslt_vld),
    .rslt_hit  (rslt_hit),
    .rslt_addr (rslt_addr),
    .rslt_nen  (rslt_nen)
);

// File: tb/cgcam_tb.sv
module cgcam_tb;
    import cgcam_pkg::*;

    localparam int ENTRIES = 16;
    localparam int TAG_W   = 16;
    localparam int RED_W   = 8;
    localparam int SUB_W   = 4;
    localparam int GRP     = 4;
    localparam int NGRP    = ENTRIES / GRP;
    localparam int CLUST   = RED_W / SUB_W;
    localparam int ROWS    = 1 << SUB_W;
    localparam int AW      = $clog2(ENTRIES);
    localparam int CW      = $clog2(NGRP + 1);

    typedef struct packed {
        cgcam_op_e        op;
        logic [AW-1:0]    addr;
        logic [TAG_W-1:0] tag;
        logic             exp_hit;
        logic [AW-1:0]    exp_addr;
    } vec_t;

    localparam int NVEC = 16;
    localparam vec_t VEC [NVEC] = '{
        '{OP_WRITE,  4'd3,  16'h1234, 1'b0, 4'd0},
        '{OP_WRITE,  4'd9,  16'hA5C7, 1'b0, 4'd0},
        '{OP_SEARCH, 4'd0,  16'h1234, 1'b1, 4'd3},   // R2
        '{OP_SEARCH, 4'd0,  16'hA5C7, 1'b1, 4'd9},   // R2
        '{OP_SEARCH, 4'd0,  16'h0055, 1'b0, 4'd0},   // R4
        '{OP_WRITE,  4'd12, 16'h1234, 1'b0, 4'd0},
        '{OP_SEARCH, 4'd0,  16'h1234, 1'b1, 4'd3},   // R5
        '{OP_SEARCH, 4'd0,  16'h9934, 1'b0, 4'd0},   // R7
        '{OP_WRITE,  4'd3,  16'h7777, 1'b0, 4'd0},
        '{OP_SEARCH, 4'd0,  16'h1234, 1'b1, 4'd12},  // R8
        '{OP_SEARCH, 4'd0,  16'h7777, 1'b1, 4'd3},   // R8
        '{OP_WRITE,  4'd6,  16'h00C4, 1'b0, 4'd0},
        '{OP_WRITE,  4'd6,  16'h0037, 1'b0, 4'd0},
        '{OP_SEARCH, 4'd0,  16'h0034, 1'b0, 4'd0},   // R6 R7
        '{OP_SEARCH, 4'd0,  16'h0037, 1'b1, 4'd6},   // R8
        '{OP_SEARCH, 4'd0,  16'h00C4, 1'b0, 4'd0}    // R8
    };

    logic             clk = 1'b0;
    logic             rst_n;
    logic             wr_en;
    logic [AW-1:0]    wr_addr;
    logic [TAG_W-1:0] wr_tag;
    logic             srch_en;
    logic [TAG_W-1:0] srch_tag;
    logic             rslt_vld;
    logic             rslt_hit;
    logic [AW-1:0]    rslt_addr;
    logic [CW-1:0]    rslt_nen;

    int  checks   = 0;
    int  failures = 0;
    bit  done     = 0;
    bit  conn [CLUST][ROWS][ENTRIES];

    always #2.5 clk = ~clk;

    cgcam #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .RED_W(RED_W), .SUB_W(SUB_W), .GRP(GRP)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_tag(wr_tag),
        .srch_en(srch_en), .srch_tag(srch_tag), .rslt_vld(rslt_vld), .rslt_hit(rslt_hit),
        .rslt_addr(rslt_addr), .rslt_nen(rslt_nen)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int k = 0; k < CLUST; k++)
            for (int r = 0; r < ROWS; r++)
                for (int e = 0; e < ENTRIES; e++) conn[k][r][e] = 0;
    endtask

    task automatic model_write(input logic [AW-1:0] a, input logic [TAG_W-1:0] t);
        for (int k = 0; k < CLUST; k++) conn[k][t[k*SUB_W +: SUB_W]][a] = 1;
    endtask

    // Expected enabled sub-block count per R6.
    function automatic int model_nen(input logic [TAG_W-1:0] t);
        int n = 0;
        for (int g = 0; g < NGRP; g++) begin
            bit any = 0;
            for (int e = g * GRP; e < (g + 1) * GRP; e++) begin
                bit all = 1;
                for (int k = 0; k < CLUST; k++)
                    if (!conn[k][t[k*SUB_W +: SUB_W]][e]) all = 0;
                if (all) any = 1;
            end
            if (any) n++;
        end
        return n;
    endfunction

    task automatic do_write(input logic [AW-1:0] a, input logic [TAG_W-1:0] t);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_tag = t;
        @(negedge clk);
        wr_en = 1'b0;
        model_write(a, t);
    endtask

    task automatic do_search(input logic [TAG_W-1:0] t, input bit eh, input int ea, input string req);
        int en;
        en = model_nen(t);
        @(negedge clk);
        srch_en = 1'b1; srch_tag = t;
        @(negedge clk);
        srch_en = 1'b0;
        check({req, " R3 strobe"}, rslt_vld, 1);
        check({req, " hit"}, rslt_hit, eh);
        check({req, " addr"}, rslt_addr, ea);
        check({req, " R6 nen"}, rslt_nen, en);
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model_clear();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int held_nen;
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_tag = '0;
        srch_en = 1'b0; srch_tag = '0;
        model_clear();
        repeat (3) @(negedge clk);
        // R1: outputs cleared while reset is held
        check("R1 vld", rslt_vld, 0);
        check("R1 hit", rslt_hit, 0);
        check("R1 addr", rslt_addr, 0);
        check("R1 nen", rslt_nen, 0);
        rst_n = 1'b1;
        do_search(16'h1234, 0, 0, "R1 empty search");

        // Table walk
        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i].op == OP_WRITE) do_write(VEC[i].addr, VEC[i].tag);
            else do_search(VEC[i].tag, VEC[i].exp_hit, int'(VEC[i].exp_addr),
                           $sformatf("vec%0d R2/R4/R5/R7/R8", i));
        end

        // R3, R10: strobe drops and fields hold when no search follows
        held_nen = int'(rslt_nen);
        @(negedge clk);
        check("R3 strobe low", rslt_vld, 0);
        check("R10 hit hold", rslt_hit, 0);
        check("R10 nen hold", rslt_nen, held_nen);

        // R7: reduced bits shared, full tag absent, classifier still enables
        check("R7 false positive enabled", int'(model_nen(16'h5534) != 0), 1);
        do_search(16'h5534, 0, 0, "R7 filtered");

        // R9: write and search in the same cycle
        begin
            int en0;
            en0 = model_nen(16'hBEEF);
            @(negedge clk);
            wr_en = 1'b1; wr_addr = 4'd0; wr_tag = 16'hBEEF;
            srch_en = 1'b1; srch_tag = 16'hBEEF;
            @(negedge clk);
            wr_en = 1'b0; srch_en = 1'b0;
            model_write(4'd0, 16'hBEEF);
            check("R9 same-cycle hit", rslt_hit, 0);
            check("R9 same-cycle nen", rslt_nen, en0);
        end
        do_search(16'hBEEF, 1, 0, "R9 after write R2");
        do_search(16'h1234, 1, 12, "R5 still lowest");

        // R1: reset in mid-run clears entries and connections
        apply_reset();
        check("R1 post-reset vld", rslt_vld, 0);
        check("R1 post-reset nen", rslt_nen, 0);
        do_search(16'hBEEF, 0, 0, "R1 cleared");
        do_search(16'h1234, 0, 0, "R1 cleared");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule